// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a byte stream of incoming Ethernet frames and stores each frame in a ring of fixed-size receive buffers held in shared memory. Every buffer is described by a two-word descriptor. The first word holds the buffer address together with an ownership flag and an end-of-ring flag. The second word receives status. Before it uses a buffer, the block reads its descriptor and refuses any buffer that software has not yet handed back. It fills the buffer one 32-bit word at a time. It then writes the status word and sets the ownership flag. A frame longer than one buffer continues in the next descriptor. That includes the step from the last ring entry back to the ring base.

Software sets the ring base and raises the receive enable. The ring position returns to the base each time the enable rises. When a frame cannot be stored because no buffer is free, or because the ring fills partway through the frame, the frame is discarded and a one-cycle status pulse says which of the two cases happened. A completed frame produces a done pulse with its length.

Top module: `rx_ring_writer`

## Requirements
- R1: Descriptors are 8 bytes apart starting at the ring base. The address word is at the descriptor's byte address and the status word is at that address plus 4. The memory port carries word addresses, which are byte address bits 31:2.
- R2: Before writing any byte into a buffer, the block reads that buffer's address word. If bit 0 of that word is 1, the block writes nothing to that buffer or to its descriptor.
- R3: Frame bytes go into the buffer at (address word with bits 1:0 cleared) plus their offset within the buffer. Byte n of a data word sits in bits 8n+7:8n, and unused bytes in the last word are zero. A buffer holds at most 128 bytes, and further bytes continue in the next descriptor.
- R4: After the data of a buffer, the block writes the status word and then rewrites the address word with bit 0 set, leaving its other bits unchanged.
- R5: In the status word, bit 14 is 1 only in the first buffer of a frame and bit 15 is 1 only in the last. Bits 12:0 hold the total frame length in the last buffer and are 0 in every other buffer. All other bits are 0.
- R6: When the address word has bit 1 set, the next descriptor used is the one at the ring base. This applies between frames and within a frame.
- R7: If the descriptor is owned when a frame starts, the frame's bytes are consumed and discarded, bna_pulse is high for one cycle, and the next frame tries the same descriptor again.
- R8: If the next descriptor is owned partway through a frame, ovr_pulse is high for one cycle and the rest of the frame is discarded. No descriptor of that frame gets bit 15, and the next frame starts at the owned descriptor.
- R9: After the last descriptor of a frame has been handed back, frame_done is high for one cycle. While it is high, frame_len equals the frame's byte count.
- R10: While rx_en is low, all input bytes are accepted and discarded. When rx_en is high and no frame is in progress, a byte without in_sof is also discarded. A rising edge of rx_en returns the ring position to ring_base.
- R11: While reset is asserted, there is no memory request and no status pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; its rising edge restarts the ring |
| ring_base | input | 32 | Byte address of the first descriptor |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory access request, single cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 30 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the cycle after a read request |
| frame_done | output | 1 | Frame fully stored |
| frame_len | output | 13 | Length of the frame just completed |
| bna_pulse | output | 1 | Frame dropped because no buffer was free at its start |
| ovr_pulse | output | 1 | Frame abandoned because the ring filled partway through it |

## Verification
A wrong ring pointer appears at the ports in the very next descriptor read or write-back, because the memory address no longer matches the descriptor the reference expects. A packing or offset fault shows up in the first data word written after it, and a wrong length count shows up in the status word of the last buffer. Because every memory write and every status pulse is compared against the reference in the cycle it appears, an error in ownership handling is caught either as an unexpected write to an owned descriptor or as a missing or wrong pulse within a few cycles of the frame start.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  localparam int unsigned LEN_W    = 13;
  localparam int unsigned OWN_BIT  = 0;
  localparam int unsigned WRAP_BIT = 1;
  localparam int unsigned SOF_BIT  = 14;
  localparam int unsigned EOF_BIT  = 15;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_RECV,
    S_PUT,
    S_STAT,
    S_OWN,
    S_DROP
  } rxw_state_e;

  // status word written back into the second descriptor word
  function automatic logic [31:0] status_word(input logic first, input logic last,
                                              input logic [LEN_W-1:0] len);
    return {16'h0, last, first, 1'b0, (last ? len : {LEN_W{1'b0}})};
  endfunction

  // place one byte into its lane of the word being assembled
  function automatic logic [31:0] lane_merge(input logic [31:0] w, input logic [1:0] lane,
                                             input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[8*lane +: 8] = b;
    return r;
  endfunction

  // buffer start address: flag bits removed
  function automatic logic [31:0] buf_base(input logic [31:0] aw);
    return {aw[31:2], 2'b00};
  endfunction

endpackage

// File: rtl/rxw_packer.sv
module rxw_packer #(
  parameter int unsigned BUF_BYTES = 128,
  localparam int unsigned OFF_W = $clog2(BUF_BYTES) + 1,
  localparam int unsigned LEN_W = rxw_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             buf_start,
  input  logic             take,
  input  logic [7:0]       byte_in,
  input  logic             flush,
  output logic [31:0]      word,
  output logic [OFF_W-1:0] boff,
  output logic [LEN_W-1:0] flen
);
  import rxw_pkg::*;

  logic [31:0] acc_q;
  logic [OFF_W-1:0] off_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      off_q <= '0;
      len_q <= '0;
    end else begin
      if (frame_start) begin
        acc_q <= '0;
        off_q <= '0;
        len_q <= '0;
      end else if (buf_start) begin
        acc_q <= '0;
        off_q <= '0;
      end else if (take) begin
        acc_q <= lane_merge(acc_q, off_q[1:0], byte_in);
        off_q <= off_q + OFF_W'(1);
        len_q <= len_q + LEN_W'(1);
      end else if (flush) begin
        acc_q <= '0;
      end
    end
  end

  assign word = acc_q;
  assign boff = off_q;
  assign flen = len_q;

  AST_OFF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= OFF_W'(BUF_BYTES)); // R3

endmodule

// File: rtl/rxw_ring_ptr.sv
module rxw_ring_ptr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              restart,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] desc_ptr
);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (restart) begin
      ptr_q <= ring_base;
    end else if (advance) begin
      ptr_q <= wrap ? ring_base : ptr_q + ADDR_W'(DESC_BYTES);
    end
  end

  assign desc_ptr = ptr_q;

  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap && !restart) |=> (ptr_q == $past(ring_base))); // R6

  AST_RESTART_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ptr_q == $past(ring_base))); // R10

endmodule

// File: rtl/rxw_events.sv
module rxw_events #(
  localparam int unsigned LEN_W = rxw_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_ev,
  input  logic             bna_ev,
  input  logic             ovr_ev,
  input  logic [LEN_W-1:0] len_in,
  output logic             frame_done,
  output logic [LEN_W-1:0] frame_len,
  output logic             bna_pulse,
  output logic             ovr_pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_done <= 1'b0;
      bna_pulse  <= 1'b0;
      ovr_pulse  <= 1'b0;
      frame_len  <= '0;
    end else begin
      frame_done <= done_ev;
      bna_pulse  <= bna_ev;
      ovr_pulse  <= ovr_ev;
      if (done_ev) frame_len <= len_in;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_done, bna_pulse, ovr_pulse})); // R9

  AST_DONE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len != '0)); // R9

  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    bna_pulse |=> !bna_pulse); // R7

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUF_BYTES = 128,
  parameter int unsigned DESC_BYTES = 8,
  localparam int unsigned LEN_W = rxw_pkg::LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              frame_done,
  output logic [LEN_W-1:0]  frame_len,
  output logic              bna_pulse,
  output logic              ovr_pulse
);
  import rxw_pkg::*;

  localparam int unsigned OFF_W = $clog2(BUF_BYTES) + 1;
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BUF_BYTES - 1);
  localparam logic [OFF_W-1:0] OFF_FULL = OFF_W'(BUF_BYTES);

  rxw_state_e st, st_n;
  logic en_q, restart;
  logic first_q, eof_q;
  logic [31:0] aw_q;
  logic [ADDR_W-1:0] desc_ptr, buf_addr, mem_addr_b;
  logic [OFF_W-1:0] pk_off, off_word;
  logic [LEN_W-1:0] pk_len;
  logic [31:0] pk_word;
  logic ld_aw, pk_frame, pk_buf, pk_take, pk_flush, adv;
  logic done_ev, bna_ev, ovr_ev;
  logic req_c, we_c;

  // named events for the assertions
  logic ev_data_wr, ev_stat_wr, ev_own_wr;

  assign restart  = rx_en & ~en_q;
  assign buf_addr = ADDR_W'(buf_base(aw_q));
  assign off_word = (pk_off - OFF_W'(1)) & ~OFF_W'(3);

  always_comb begin
    if (!rx_en) begin
      in_ready = 1'b1;
    end else begin
      case (st)
        S_IDLE:          in_ready = !(in_valid && in_sof);
        S_RECV, S_DROP:  in_ready = 1'b1;
        default:         in_ready = 1'b0;
      endcase
    end
  end

  always_comb begin
    st_n       = st;
    ld_aw      = 1'b0;
    pk_frame   = 1'b0;
    pk_buf     = 1'b0;
    pk_take    = 1'b0;
    pk_flush   = 1'b0;
    adv        = 1'b0;
    done_ev    = 1'b0;
    bna_ev     = 1'b0;
    ovr_ev     = 1'b0;
    req_c      = 1'b0;
    we_c       = 1'b0;
    mem_addr_b = '0;
    mem_wdata  = '0;
    case (st)
      S_IDLE: begin
        if (in_valid && in_sof) st_n = S_FETCH;
      end
      S_FETCH: begin
        req_c      = 1'b1;
        mem_addr_b = desc_ptr;
        st_n       = S_CHECK;
      end
      S_CHECK: begin
        if (mem_rdata[OWN_BIT]) begin
          if (first_q) bna_ev = 1'b1;
          else         ovr_ev = 1'b1;
          st_n = S_DROP;
        end else begin
          ld_aw = 1'b1;
          if (first_q) pk_frame = 1'b1;
          else         pk_buf   = 1'b1;
          st_n = S_RECV;
        end
      end
      S_RECV: begin
        if (in_valid) begin
          pk_take = 1'b1;
          if (pk_off[1:0] == 2'd3 || in_eof || pk_off == OFF_LAST) st_n = S_PUT;
        end
      end
      S_PUT: begin
        req_c      = 1'b1;
        we_c       = 1'b1;
        mem_addr_b = buf_addr + ADDR_W'(off_word);
        mem_wdata  = pk_word;
        pk_flush   = 1'b1;
        st_n       = (eof_q || pk_off == OFF_FULL) ? S_STAT : S_RECV;
      end
      S_STAT: begin
        req_c      = 1'b1;
        we_c       = 1'b1;
        mem_addr_b = desc_ptr + ADDR_W'(4);
        mem_wdata  = status_word(first_q, eof_q, pk_len);
        st_n       = S_OWN;
      end
      S_OWN: begin
        req_c      = 1'b1;
        we_c       = 1'b1;
        mem_addr_b = desc_ptr;
        mem_wdata  = aw_q | 32'h1;
        adv        = 1'b1;
        if (eof_q) begin
          done_ev = 1'b1;
          st_n    = S_IDLE;
        end else begin
          st_n = S_FETCH;
        end
      end
      S_DROP: begin
        if (in_valid && in_eof) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
    if (!rx_en) begin
      st_n    = S_IDLE;
      adv     = 1'b0;
      done_ev = 1'b0;
      bna_ev  = 1'b0;
      ovr_ev  = 1'b0;
      pk_take = 1'b0;
    end
  end

  assign mem_req  = req_c & rx_en;
  assign mem_we   = we_c & rx_en;
  assign mem_addr = mem_addr_b[ADDR_W-1:2];

  assign ev_data_wr = mem_req & mem_we & (st == S_PUT);
  assign ev_stat_wr = mem_req & mem_we & (st == S_STAT);
  assign ev_own_wr  = mem_req & mem_we & (st == S_OWN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      en_q    <= 1'b0;
      first_q <= 1'b0;
      eof_q   <= 1'b0;
      aw_q    <= '0;
    end else begin
      st   <= st_n;
      en_q <= rx_en;
      if (!rx_en) begin
        first_q <= 1'b0;
        eof_q   <= 1'b0;
      end else begin
        if (st == S_IDLE && st_n == S_FETCH) begin
          first_q <= 1'b1;
          eof_q   <= 1'b0;
        end
        if (pk_take && in_eof) eof_q <= 1'b1;
        if (st == S_OWN) first_q <= 1'b0;
        if (ld_aw) aw_q <= mem_rdata;
      end
    end
  end

  rxw_packer #(.BUF_BYTES(BUF_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .frame_start(pk_frame), .buf_start(pk_buf),
    .take(pk_take), .byte_in(in_data), .flush(pk_flush),
    .word(pk_word), .boff(pk_off), .flen(pk_len)
  );

  rxw_ring_ptr #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
    .restart(restart), .advance(adv), .wrap(aw_q[WRAP_BIT]),
    .desc_ptr(desc_ptr)
  );

  rxw_events u_ev (
    .clk(clk), .rst_n(rst_n),
    .done_ev(done_ev), .bna_ev(bna_ev), .ovr_ev(ovr_ev), .len_in(pk_len),
    .frame_done(frame_done), .frame_len(frame_len),
    .bna_pulse(bna_pulse), .ovr_pulse(ovr_pulse)
  );

  AST_OWN_AFTER_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own_wr |-> $past(ev_stat_wr)); // R4

  AST_STAT_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_wr |-> $past(ev_data_wr)); // R3

  AST_DATA_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_wr |-> ((mem_addr_b - buf_addr) < ADDR_W'(BUF_BYTES))); // R3

  AST_NOEND_NO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stat_wr && !mem_wdata[EOF_BIT]) |-> (mem_wdata[LEN_W-1:0] == '0)); // R5

  AST_OWN_KEEPS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own_wr |-> (mem_wdata[OWN_BIT] && mem_wdata[WRAP_BIT] == aw_q[WRAP_BIT])); // R4

  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !mem_req); // R10

endmodule

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
  localparam int CLK_NS = 10;
  localparam int NDESC = 4;
  localparam logic [31:0] RBASE = 32'h100;

  logic clk = 0;
  logic rst_n = 0;
  logic rx_en = 0;
  logic [31:0] ring_base = RBASE;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic frame_done, bna_pulse, ovr_pulse;
  logic [12:0] frame_len;

  always #(CLK_NS/2) clk = ~clk;

  rx_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .frame_done(frame_done),
    .frame_len(frame_len), .bna_pulse(bna_pulse), .ovr_pulse(ovr_pulse)
  );

  logic [31:0] mem [0:2047];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[10:0]];
    end
  end

  int checks = 0, errors = 0;
  string cur_req = "R11";
  logic [31:0] exp_a[$], exp_d[$];
  int ev_k[$], ev_l[$];
  bit mdl_own [0:NDESC-1];
  int mdl_pos = 0;
  logic [7:0] fb [0:511];

  function automatic logic [31:0] desc_b(int i); return RBASE + 32'(8*i); endfunction
  function automatic logic [31:0] buf_b(int i); return 32'h1000 + 32'(128*i); endfunction
  function automatic logic [31:0] aw(int i);
    return buf_b(i) | ((i == NDESC-1) ? 32'h2 : 32'h0);
  endfunction

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // per-clock comparison of memory writes and status pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we) begin
        if (exp_a.size() == 0) chk(0, "unexpected write", {mem_addr, 2'b00}, 32'h0);
        else begin
          logic [31:0] ea, ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk({mem_addr, 2'b00} == ea, "write address", {mem_addr, 2'b00}, ea);
          chk(mem_wdata == ed, "write data", mem_wdata, ed);
        end
      end
      if (frame_done || bna_pulse || ovr_pulse) begin
        int k;
        k = frame_done ? 0 : (bna_pulse ? 1 : 2);
        if (ev_k.size() == 0) chk(0, "unexpected pulse", 32'(k), 32'hffffffff);
        else begin
          int ek, el;
          ek = ev_k.pop_front();
          el = ev_l.pop_front();
          chk(k == ek, "pulse kind", 32'(k), 32'(ek));
          if (ek == 0 && k == 0) chk(frame_len == 13'(el), "frame_len", 32'(frame_len), 32'(el));
        end
      end
    end
  end

  task automatic model_frame(int len);
    int k;
    bit first;
    k = 0;
    first = 1;
    while (1) begin
      int n;
      bit last;
      if (mdl_own[mdl_pos]) begin
        ev_k.push_back(first ? 1 : 2);
        ev_l.push_back(0);
        return;
      end
      n = (len - k > 128) ? 128 : len - k;
      for (int b = 0; b < n; b += 4) begin
        logic [31:0] w;
        w = 0;
        for (int ln = 0; ln < 4; ln++)
          if (b + ln < n) w = w | (32'(fb[k+b+ln]) << (8*ln));
        exp_a.push_back(buf_b(mdl_pos) + 32'(b));
        exp_d.push_back(w);
      end
      last = (k + n == len);
      exp_a.push_back(desc_b(mdl_pos) + 4);
      exp_d.push_back({16'h0, last, first, 1'b0, (last ? 13'(len) : 13'h0)});
      exp_a.push_back(desc_b(mdl_pos));
      exp_d.push_back(aw(mdl_pos) | 32'h1);
      mdl_own[mdl_pos] = 1;
      mdl_pos = (mdl_pos == NDESC-1) ? 0 : mdl_pos + 1;
      if (last) begin
        ev_k.push_back(0);
        ev_l.push_back(len);
        return;
      end
      first = 0;
      k += n;
    end
  endtask

  task automatic put_byte(logic [7:0] d, logic s, logic e);
    @(negedge clk);
    in_valid = 1; in_data = d; in_sof = s; in_eof = e;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic send_bytes(int len, int seed, bit framed);
    for (int j = 0; j < len; j++) fb[j] = 8'(seed*37 + j*5 + 1);
    for (int j = 0; j < len; j++)
      put_byte(fb[j], framed && (j == 0), framed && (j == len-1));
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic wait_quiet();
    int t;
    t = 0;
    while ((exp_a.size() != 0 || ev_k.size() != 0) && t < 3000) begin @(negedge clk); t++; end
    chk(exp_a.size() == 0, "pending writes", 32'(exp_a.size()), 0);
    chk(ev_k.size() == 0, "pending pulses", 32'(ev_k.size()), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(int len, int seed);
    for (int j = 0; j < len; j++) fb[j] = 8'(seed*37 + j*5 + 1);
    model_frame(len);
    send_bytes(len, seed, 1);
    wait_quiet();
  endtask

  task automatic free_all();
    for (int i = 0; i < NDESC; i++) begin
      mem[desc_b(i) >> 2] = aw(i);
      mem[(desc_b(i) >> 2) + 1] = 32'h0;
      mdl_own[i] = 0;
    end
  endtask

  task automatic set_own(int i);
    mem[desc_b(i) >> 2] = aw(i) | 32'h1;
    mdl_own[i] = 1;
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
    free_all();
    repeat (4) @(negedge clk);
    cur_req = "R11";
    chk(mem_req == 0, "mem_req in reset", 32'(mem_req), 0);
    chk({frame_done, bna_pulse, ovr_pulse} == 3'b000, "pulses in reset",
        32'({frame_done, bna_pulse, ovr_pulse}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_req == 0, "mem_req after reset", 32'(mem_req), 0);
    chk(in_ready == 1, "ready while disabled", 32'(in_ready), 1);
    rx_en = 1;
    mdl_pos = 0;
    repeat (2) @(negedge clk);

    cur_req = "R1 R3 R5 R9";   run_frame(5, 1);   free_all();
    cur_req = "R3 R4";         run_frame(128, 2); free_all();
    cur_req = "R3 R6 wrap";    run_frame(300, 3); free_all();
    cur_req = "R3 R5 short";   run_frame(1, 4);   free_all();
    run_frame(4, 5); free_all();

    cur_req = "R2 R7";
    set_own(mdl_pos);
    run_frame(20, 6);
    free_all();
    cur_req = "R7 R6 retry";   run_frame(10, 7);  free_all();

    cur_req = "R2 R8";
    set_own(mdl_pos == NDESC-1 ? 0 : mdl_pos + 1);
    run_frame(200, 8);
    free_all();
    cur_req = "R8 resume";     run_frame(8, 9);   free_all();

    cur_req = "R10 stray";
    send_bytes(6, 10, 0);
    wait_quiet();

    cur_req = "R10 disabled";
    rx_en = 0;
    send_bytes(10, 11, 1);
    wait_quiet();
    rx_en = 1;
    mdl_pos = 0;
    repeat (2) @(negedge clk);
    run_frame(12, 12); free_all();

    cur_req = "R3 R5 span";    run_frame(129, 13); free_all();

    cur_req = "R4 memory";
    chk(mem[desc_b(1) >> 2] == aw(1), "descriptor freed", mem[desc_b(1) >> 2], aw(1));
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule